// File: doc/BRIEF.md
# Multiport Segmenting Write Master

This block sits between two output ports of an untimed functional IP and a narrow write-only initiator bus. The wide port carries 64-bit words with queue semantics. Its producer holds a word on a valid/ready handshake and is stalled until every byte of that word has been accepted downstream. The narrow port carries 32-bit values with signal semantics. A write strobe is always taken at once, and a newer value replaces one that has not yet started to go out.

Each word is sent as a run of 8-bit writes, lowest byte first. The bus address of every write joins three fields: the destination agent number, the destination port number, and the running byte index. The agent and port numbers for each source come from configuration inputs, and they are captured when a transfer starts. When both sources are waiting, the wide port goes first. A transfer that has started always runs to its last byte. On the bus side, a byte is offered with `m_valid` and is held unchanged until `m_ready` is seen high on a clock edge. The bus never issues reads.

Top module: `seg_write_master`

## Requirements
- R1: Every bus write has address `m_addr[4]` = agent number, `m_addr[3]` = port number, and `m_addr[2:0]` = byte index.
- R2: A wide word goes out as 8 writes and a narrow value as 4 writes. Bytes are sent least-significant first, and the index counts up from 0.
- R3: While `m_valid` is high and `m_ready` is low, `m_valid`, `m_addr` and `m_wdata` stay unchanged on the next cycle.
- R4: When both sources are waiting while the bus is idle, the wide port's word is sent before the narrow port's value.
- R5: Once a transfer has started, its bytes go out back to back in index order, with no write from the other source in between.
- R6: After `a_valid && a_ready` on an edge, `a_ready` stays low until the last byte of that word is accepted. It is high again in the cycle after that acceptance.
- R7: A `b_write` pulse is always accepted. If several pulses arrive before the narrow value starts to go out, only the newest value is sent.
- R8: Each source uses its own configured agent and port numbers (`cfg_a_*` for the wide port, `cfg_b_*` for the narrow port), sampled when its transfer starts.
- R9: After reset, `m_valid` is low and `a_ready` is high.
- R10: When no source is waiting, `m_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_a_agent | input | 1 | Destination agent number for the wide port |
| cfg_a_port | input | 1 | Destination port number for the wide port |
| cfg_b_agent | input | 1 | Destination agent number for the narrow port |
| cfg_b_port | input | 1 | Destination port number for the narrow port |
| a_valid | input | 1 | Wide port word valid |
| a_ready | output | 1 | Wide port ready; low while a word is held |
| a_data | input | 64 | Wide port word |
| b_write | input | 1 | Narrow port write strobe (never refused) |
| b_data | input | 32 | Narrow port value |
| m_valid | output | 1 | Bus write valid |
| m_ready | input | 1 | Bus write accepted |
| m_addr | output | 5 | Bus address: agent, port, byte index |
| m_wdata | output | 8 | Bus write byte |

## Verification
The assertions check on every cycle that a stalled bus write holds steady, that a run begins at index 0 and then steps through consecutive indices to the same destination, and that the wide producer stays blocked once its word has been taken. Only the bench scenarios can show the byte order and values of each word, the order between sources when both are waiting, the replacement of an unsent narrow value by a newer one, the use of the configured destinations, and the return of the wide port's ready.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int AGENT_W = 1;
  localparam int PORT_W  = 1;
  localparam int IDX_W   = 3;
  localparam int BUS_W   = 8;
  localparam int ADDR_W  = AGENT_W + PORT_W + IDX_W;

  typedef enum logic {SRC_WIDE = 1'b0, SRC_NARROW = 1'b1} src_e;
endpackage

// File: rtl/queue_slot.sv
module queue_slot #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         done,
  output logic         pend,
  output logic [W-1:0] hold
);
  logic full;

  assign in_ready = !full;
  assign pend     = full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      hold <= '0;
    end else if (in_valid && !full) begin
      full <= 1'b1;
      hold <= in_data;
    end else if (done) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/latest_slot.sv
module latest_slot #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wr_data,
  input  logic         take,
  output logic         pend,
  output logic [W-1:0] hold
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0;
      hold <= '0;
    end else if (wr) begin
      pend <= 1'b1;
      hold <= wr_data;
    end else if (take) begin
      pend <= 1'b0;
    end
  end
endmodule

// File: rtl/seg_engine.sv
module seg_engine
  import seg_pkg::*;
#(
  parameter int WIDE_W   = 64,
  parameter int NARROW_W = 32,
  parameter int AG_W     = AGENT_W,
  parameter int PT_W     = PORT_W,
  parameter int IX_W     = IDX_W,
  parameter int B_W      = BUS_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     a_pend,
  input  logic [WIDE_W-1:0]        a_word,
  input  logic                     b_pend,
  input  logic [NARROW_W-1:0]      b_word,
  input  logic [AG_W-1:0]          cfg_a_agent,
  input  logic [PT_W-1:0]          cfg_a_port,
  input  logic [AG_W-1:0]          cfg_b_agent,
  input  logic [PT_W-1:0]          cfg_b_port,
  output logic                     m_valid,
  input  logic                     m_ready,
  output logic [AG_W+PT_W+IX_W-1:0] m_addr,
  output logic [B_W-1:0]           m_wdata,
  output logic                     take_b,
  output logic                     done_a,
  output logic                     seg_last
);
  localparam logic [IX_W-1:0] WIDE_LAST   = IX_W'(WIDE_W / B_W - 1);
  localparam logic [IX_W-1:0] NARROW_LAST = IX_W'(NARROW_W / B_W - 1);

  logic              busy;
  src_e              src;
  logic [IX_W-1:0]   idx;
  logic [WIDE_W-1:0] shreg;
  logic [AG_W-1:0]   agent_q;
  logic [PT_W-1:0]   port_q;
  logic [IX_W-1:0]   last_idx;
  logic              at_last;

  assign last_idx = (src == SRC_NARROW) ? NARROW_LAST : WIDE_LAST;
  assign at_last  = (idx == last_idx);
  assign m_valid  = busy;
  assign m_addr   = {agent_q, port_q, idx};
  assign m_wdata  = shreg[B_W-1:0];
  assign take_b   = !busy && !a_pend && b_pend;
  assign done_a   = busy && m_ready && at_last && (src == SRC_WIDE);
  assign seg_last = busy && at_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      src     <= SRC_WIDE;
      idx     <= '0;
      shreg   <= '0;
      agent_q <= '0;
      port_q  <= '0;
    end else if (!busy) begin
      idx <= '0;
      if (a_pend) begin
        busy    <= 1'b1;
        src     <= SRC_WIDE;
        shreg   <= a_word;
        agent_q <= cfg_a_agent;
        port_q  <= cfg_a_port;
      end else if (b_pend) begin
        busy    <= 1'b1;
        src     <= SRC_NARROW;
        shreg   <= WIDE_W'(b_word);
        agent_q <= cfg_b_agent;
        port_q  <= cfg_b_port;
      end
    end else if (m_ready) begin
      if (at_last) busy <= 1'b0;
      idx   <= idx + 1'b1;
      shreg <= shreg >> B_W;
    end
  end
endmodule

// File: rtl/seg_write_master.sv
module seg_write_master
  import seg_pkg::*;
#(
  parameter int WIDE_W   = 64,
  parameter int NARROW_W = 32,
  parameter int AG_W     = AGENT_W,
  parameter int PT_W     = PORT_W,
  parameter int IX_W     = IDX_W,
  parameter int B_W      = BUS_W,
  localparam int A_W     = AG_W + PT_W + IX_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [AG_W-1:0]     cfg_a_agent,
  input  logic [PT_W-1:0]     cfg_a_port,
  input  logic [AG_W-1:0]     cfg_b_agent,
  input  logic [PT_W-1:0]     cfg_b_port,
  input  logic                a_valid,
  output logic                a_ready,
  input  logic [WIDE_W-1:0]   a_data,
  input  logic                b_write,
  input  logic [NARROW_W-1:0] b_data,
  output logic                m_valid,
  input  logic                m_ready,
  output logic [A_W-1:0]      m_addr,
  output logic [B_W-1:0]      m_wdata
);
  logic                a_pend, b_pend, take_b, done_a, seg_last;
  logic [WIDE_W-1:0]   a_word;
  logic [NARROW_W-1:0] b_word;

  queue_slot #(.W(WIDE_W)) u_qslot (
    .clk(clk), .rst_n(rst_n), .in_valid(a_valid), .in_ready(a_ready),
    .in_data(a_data), .done(done_a), .pend(a_pend), .hold(a_word)
  );

  latest_slot #(.W(NARROW_W)) u_lslot (
    .clk(clk), .rst_n(rst_n), .wr(b_write), .wr_data(b_data),
    .take(take_b), .pend(b_pend), .hold(b_word)
  );

  seg_engine #(
    .WIDE_W(WIDE_W), .NARROW_W(NARROW_W), .AG_W(AG_W), .PT_W(PT_W),
    .IX_W(IX_W), .B_W(B_W)
  ) u_eng (
    .clk(clk), .rst_n(rst_n), .a_pend(a_pend), .a_word(a_word),
    .b_pend(b_pend), .b_word(b_word),
    .cfg_a_agent(cfg_a_agent), .cfg_a_port(cfg_a_port),
    .cfg_b_agent(cfg_b_agent), .cfg_b_port(cfg_b_port),
    .m_valid(m_valid), .m_ready(m_ready), .m_addr(m_addr), .m_wdata(m_wdata),
    .take_b(take_b), .done_a(done_a), .seg_last(seg_last)
  );
endmodule

// File: rtl/seg_write_master_chk.sv
module seg_write_master_chk #(
  parameter int A_W  = 5,
  parameter int IX_W = 3,
  parameter int B_W  = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           a_valid,
  input logic           a_ready,
  input logic           m_valid,
  input logic           m_ready,
  input logic [A_W-1:0] m_addr,
  input logic [B_W-1:0] m_wdata,
  input logic           seg_last
);
  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_wdata)));

  // R2
  run_starts_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_valid) |-> (m_addr[IX_W-1:0] == '0));

  // R5
  no_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready && !seg_last) |=>
      (m_valid && m_addr[A_W-1:IX_W] == $past(m_addr[A_W-1:IX_W]) &&
       m_addr[IX_W-1:0] == $past(m_addr[IX_W-1:0]) + 1'b1));

  // R6
  producer_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && a_ready) |=> !a_ready);
endmodule

bind seg_write_master seg_write_master_chk #(.A_W(A_W), .IX_W(IX_W), .B_W(B_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_valid(a_valid), .a_ready(a_ready),
  .m_valid(m_valid), .m_ready(m_ready), .m_addr(m_addr), .m_wdata(m_wdata),
  .seg_last(seg_last)
);

// File: tb/sim_seg_write_master.sv
`timescale 1ns/1ps
module sim_seg_write_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_a_agent = 1'b1, cfg_a_port = 1'b0;
  logic        cfg_b_agent = 1'b0, cfg_b_port = 1'b1;
  logic        a_valid = 1'b0;
  logic        a_ready;
  logic [63:0] a_data = '0;
  logic        b_write = 1'b0;
  logic [31:0] b_data = '0;
  logic        m_valid;
  logic        m_ready = 1'b1;
  logic [4:0]  m_addr;
  logic [7:0]  m_wdata;

  int tests = 0, fails = 0;
  int rdy_mode = 0;
  int cap_n = 0;
  logic [4:0] cap_addr [64];
  logic [7:0] cap_data [64];
  int tick = 0;

  always #2 clk = ~clk;

  seg_write_master u0 (.*);

  always @(posedge clk) begin
    if (rst_n && m_valid && m_ready && cap_n < 64) begin
      cap_addr[cap_n] = m_addr;
      cap_data[cap_n] = m_wdata;
      cap_n = cap_n + 1;
    end
  end

  always @(negedge clk) begin
    tick = tick + 1;
    if (rdy_mode == 0) m_ready = 1'b1;
    else if (rdy_mode == 1) m_ready = tick[0];
    else m_ready = 1'b0;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_caps(input int n, input string req);
    int k;
    k = 0;
    while (cap_n < n && k < 500) begin
      @(negedge clk);
      k++;
    end
    check(cap_n >= n, req, 64'(cap_n), 64'(n));
  endtask

  task automatic check_run(input int base, input int segs, input logic ag, input logic pt,
                           input logic [63:0] val, input string req);
    for (int i = 0; i < segs; i++) begin
      logic [12:0] act, exp;
      act = {cap_addr[base+i], cap_data[base+i]};
      exp = {ag, pt, 3'(i), 8'(val >> (8*i))};
      check(act == exp, req, 64'(act), 64'(exp));
    end
  endtask

  task automatic send_a(input logic [63:0] v);
    @(negedge clk);
    a_valid = 1'b1;
    a_data  = v;
    do @(posedge clk); while (!a_ready);
    @(negedge clk);
    a_valid = 1'b0;
  endtask

  task automatic pulse_b(input logic [31:0] v);
    @(negedge clk);
    b_write = 1'b1;
    b_data  = v;
    @(negedge clk);
    b_write = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(m_valid == 1'b0, "R9 m_valid", 64'(m_valid), 64'd0);
    check(a_ready == 1'b1, "R9 a_ready", 64'(a_ready), 64'd1);
  endtask

  // R1 R2 R8 R6: wide word at full rate
  task automatic t_wide();
    cap_n = 0;
    send_a(64'h8877_6655_4433_2211);
    check(a_ready == 1'b0, "R6 held low", 64'(a_ready), 64'd0);
    wait_caps(8, "R2 wide count");
    @(negedge clk);
    check(a_ready == 1'b1, "R6 ready back", 64'(a_ready), 64'd1);
    check_run(0, 8, 1'b1, 1'b0, 64'h8877_6655_4433_2211, "R1 R2 wide run");
  endtask

  // R2 R8 R3: narrow value with a toggling acceptor
  task automatic t_narrow_stall();
    cap_n = 0;
    rdy_mode = 1;
    pulse_b(32'hDEAD_BEEF);
    wait_caps(4, "R2 narrow count");
    rdy_mode = 0;
    check_run(0, 4, 1'b0, 1'b1, 64'hDEAD_BEEF, "R8 R3 narrow run");
  endtask

  // R3 R6: acceptor held off entirely
  task automatic t_block();
    logic [4:0] a0;
    cap_n = 0;
    rdy_mode = 2;
    send_a(64'h0102_0304_0506_0708);
    repeat (3) @(negedge clk);
    a0 = m_addr;
    repeat (6) @(negedge clk);
    check(m_valid && m_addr == a0 && m_wdata == 8'h08, "R3 held", {m_addr, m_wdata}, {a0, 8'h08});
    check(a_ready == 1'b0, "R6 stalled producer", 64'(a_ready), 64'd0);
    rdy_mode = 0;
    wait_caps(8, "R6 drain");
    @(negedge clk);
    check(a_ready == 1'b1, "R6 release", 64'(a_ready), 64'd1);
    check_run(0, 8, 1'b1, 1'b0, 64'h0102_0304_0506_0708, "R3 stalled run");
  endtask

  // R4: both sources in the same cycle
  task automatic t_prio();
    cap_n = 0;
    @(negedge clk);
    a_valid = 1'b1; a_data = 64'hA1A2_A3A4_A5A6_A7A8;
    b_write = 1'b1; b_data = 32'hB1B2_B3B4;
    @(negedge clk);
    a_valid = 1'b0; b_write = 1'b0;
    wait_caps(12, "R4 count");
    check_run(0, 8, 1'b1, 1'b0, 64'hA1A2_A3A4_A5A6_A7A8, "R4 wide first");
    check_run(8, 4, 1'b0, 1'b1, 64'hB1B2_B3B4, "R4 narrow second");
  endtask

  // R5 R7: narrow overwrites while wide is on the bus
  task automatic t_overwrite();
    cap_n = 0;
    rdy_mode = 1;
    send_a(64'hC0C1_C2C3_C4C5_C6C7);
    pulse_b(32'h1111_1111);
    pulse_b(32'h2222_3333);
    wait_caps(12, "R7 count");
    rdy_mode = 0;
    repeat (10) @(negedge clk);
    check(cap_n == 12, "R7 single narrow run", 64'(cap_n), 64'd12);
    check_run(0, 8, 1'b1, 1'b0, 64'hC0C1_C2C3_C4C5_C6C7, "R5 wide unbroken");
    check_run(8, 4, 1'b0, 1'b1, 64'h2222_3333, "R7 newest value");
  endtask

  // R8 R10: new destinations, then idle
  task automatic t_cfg_idle();
    cap_n = 0;
    cfg_a_agent = 1'b0; cfg_a_port = 1'b1;
    send_a(64'h0F0E_0D0C_0B0A_0908);
    wait_caps(8, "R8 count");
    check_run(0, 8, 1'b0, 1'b1, 64'h0F0E_0D0C_0B0A_0908, "R8 reconfigured");
    repeat (8) @(negedge clk);
    check(m_valid == 1'b0 && cap_n == 8, "R10 idle", {m_valid, 32'(cap_n)}, {1'b0, 32'd8});
  endtask

  bit finished = 0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_wide();
    t_narrow_stall();
    t_block();
    t_prio();
    t_overwrite();
    t_cfg_idle();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule